// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts on an APB Slave

This block is a general-purpose I/O peripheral reached through an APB slave port. It holds up to four ports of up to `W` pins each. For every port, software sets an output value and an output-enable (direction) vector, and it can read back the synchronised pin levels. The pins of the first port (port A) can also raise interrupts. Each of those pins picks edge or level sensing and the active polarity. It can be enabled and masked on its own, and it can be routed through a debounce filter.

Edge events are held in a sticky latch until software clears them with a write-one-to-clear register. Level events are never latched: they follow the qualified pin level. The enabled and unmasked events form a status vector, and their OR drives a single interrupt line. Every external input passes through a two-flop synchroniser before any logic uses it. The debounce filter advances on a `deb_tick` strobe from a slower time base. It takes a new level only after that level has held for `DB_TICKS` consecutive ticks.

Top module: `gpio_apb`

## Requirements
- R1: For port N (0 to 3), the output value register at byte offset 12*N drives `pins_out` and the direction register at offset 12*N+4 drives `pins_oe` (bit set = output enabled). Both read back what was written.
- R2: Reading offset 0x50+4*N returns port N's pin levels as seen through a two-flop synchroniser. A change on `pins_in` is visible no later than three clocks after it is applied.
- R3: A pin whose bit in the type register (0x38) is 1 is edge sensitive. Its polarity bit (0x3c) = 1 latches on a rising edge and = 0 latches on a falling edge. The latched event stays pending after the pin returns.
- R4: Writing 1 to a bit of the clear register (0x4c) clears that pin's latched edge. Bits written as 0 leave other pending edges untouched.
- R5: A pin whose type bit is 0 is level sensitive. It is active while its level equals its polarity bit (1 = high active, 0 = low active). It drops as soon as the level leaves, and writes to 0x4c do not affect it.
- R6: A mask bit (0x34) of 1 suppresses that pin in the status register and in `irq`. Clearing the mask reveals an active level at once.
- R7: A pin whose enable bit (0x30) is 0 never appears in the status register or on `irq`.
- R8: Only port A pins raise interrupts. Activity on ports B to D leaves `irq` low.
- R9: With its debounce bit (0x48) set, a port A pin takes a new level only after that level has held for `DB_TICKS` consecutive `deb_tick` strobes. A pulse shorter than that causes no event.
- R10: The status register (0x40) holds, one bit per pin, the pending events that are enabled and unmasked. `irq` is high exactly when any status bit is set.
- R11: After reset, all registers read zero, `pins_out` and `pins_oe` are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| deb_tick | input | 1 | Debounce time base strobe, one pclk wide |
| pins_in | input | NPORTS*W | External pin levels, port A in the low bits |
| pins_out | output | NPORTS*W | Output values |
| pins_oe | output | NPORTS*W | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench checks that a pending edge survives the pin going back. A design that does not latch would lose the event. It then clears one edge while another stays pending, which catches a clear applied to the whole vector instead of by bit. For level pins it writes the clear register and checks that the event stays active. It also checks that the event drops when the pin returns, so a level that got latched by mistake shows up. Further directed cases drive a sub-threshold glitch and a long stable pulse through the debounce filter, toggle pins on a port that has no interrupt logic, and reveal a held level by clearing its mask. Each of these exposes a filter with the wrong count, an interrupt path wired to the wrong port, or a mask that is sampled only on edges.

// File: rtl/gpio_apb.sv
module gpio_apb #(
  parameter int NPORTS   = 4,
  parameter int W        = 32,
  parameter int DB_TICKS = 4,
  parameter int AW       = 7
) (
  input  logic                 pclk,
  input  logic                 presetn,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [AW-1:0]        paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic                 deb_tick,
  input  logic [NPORTS*W-1:0]  pins_in,
  output logic [NPORTS*W-1:0]  pins_out,
  output logic [NPORTS*W-1:0]  pins_oe,
  output logic                 irq
);
  localparam int CW = $clog2(DB_TICKS + 1);
  localparam logic [AW-1:0] A_EN   = AW'(8'h30);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h34);
  localparam logic [AW-1:0] A_TYP  = AW'(8'h38);
  localparam logic [AW-1:0] A_POL  = AW'(8'h3c);
  localparam logic [AW-1:0] A_STAT = AW'(8'h40);
  localparam logic [AW-1:0] A_DEB  = AW'(8'h48);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h4c);
  localparam logic [AW-1:0] A_EXT  = AW'(8'h50);

  logic [W-1:0] out_q [NPORTS];
  logic [W-1:0] oe_q  [NPORTS];
  logic [W-1:0] en_q, msk_q, typ_q, pol_q, deb_q;
  logic [NPORTS*W-1:0] sync1, sync2;
  logic [W-1:0] flt, a_in, prev_q, latch_q, hit, lvl, status, clr;
  logic wr;

  assign wr = psel & penable & pwrite;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      for (int p = 0; p < NPORTS; p++) begin
        out_q[p] <= '0;
        oe_q[p]  <= '0;
      end
      en_q  <= '0;
      msk_q <= '0;
      typ_q <= '0;
      pol_q <= '0;
      deb_q <= '0;
    end else if (wr) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (paddr == AW'(12*p))     out_q[p] <= pwdata[W-1:0];
        if (paddr == AW'(12*p + 4)) oe_q[p]  <= pwdata[W-1:0];
      end
      if (paddr == A_EN)  en_q  <= pwdata[W-1:0];
      if (paddr == A_MSK) msk_q <= pwdata[W-1:0];
      if (paddr == A_TYP) typ_q <= pwdata[W-1:0];
      if (paddr == A_POL) pol_q <= pwdata[W-1:0];
      if (paddr == A_DEB) deb_q <= pwdata[W-1:0];
    end

  genvar gp, gi;
  generate
    for (gp = 0; gp < NPORTS; gp++) begin : g_port
      assign pins_out[gp*W +: W] = out_q[gp];
      assign pins_oe[gp*W +: W]  = oe_q[gp];
    end
  endgenerate

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pins_in;
      sync2 <= sync1;
    end

  generate
    for (gi = 0; gi < W; gi++) begin : g_deb
      logic [CW-1:0] cnt;
      logic          filt;
      always_ff @(posedge pclk or negedge presetn)
        if (!presetn) begin
          cnt  <= '0;
          filt <= 1'b0;
        end else if (!deb_q[gi]) begin
          cnt  <= '0;
          filt <= sync2[gi];
        end else if (deb_tick) begin
          if (sync2[gi] == filt) cnt <= '0;
          else if (cnt == CW'(DB_TICKS - 1)) begin
            cnt  <= '0;
            filt <= sync2[gi];
          end else cnt <= cnt + 1'b1;
        end
      assign flt[gi] = filt;
    end
  endgenerate

  assign a_in   = (deb_q & flt) | (~deb_q & sync2[W-1:0]);
  assign hit    = ((pol_q & a_in & ~prev_q) | (~pol_q & ~a_in & prev_q)) & typ_q & en_q;
  assign clr    = (wr && paddr == A_CLR) ? pwdata[W-1:0] : '0;
  assign lvl    = ~typ_q & ~(a_in ^ pol_q);
  assign status = (latch_q | lvl) & en_q & ~msk_q;
  assign irq    = |status;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= a_in;
      latch_q <= ((latch_q & ~clr) | hit) & typ_q & en_q;
    end

  always_comb begin
    prdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (paddr == AW'(12*p))     prdata = 32'(out_q[p]);
      if (paddr == AW'(12*p + 4)) prdata = 32'(oe_q[p]);
      if (paddr == A_EXT + AW'(4*p)) prdata = 32'(sync2[p*W +: W]);
    end
    case (paddr)
      A_EN:    prdata = 32'(en_q);
      A_MSK:   prdata = 32'(msk_q);
      A_TYP:   prdata = 32'(typ_q);
      A_POL:   prdata = 32'(pol_q);
      A_STAT:  prdata = 32'(status);
      A_DEB:   prdata = 32'(deb_q);
      default: ;
    endcase
  end
endmodule

module gpio_apb_chk #(
  parameter int W  = 32,
  parameter int AW = 7
) (
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [31:0]   pwdata,
  input logic [W-1:0]  oe_a,
  input logic          irq,
  input logic [W-1:0]  en,
  input logic [W-1:0]  msk,
  input logic [W-1:0]  latch,
  input logic [W-1:0]  hit
);
  assert_dir_write_R1: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == AW'(4)) |=> oe_a == $past(pwdata[W-1:0]));

  assert_clear_edge_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == AW'(8'h4c))
      |=> (latch & $past(pwdata[W-1:0]) & ~$past(hit)) == '0);

  assert_mask_all_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (msk == '1) |-> !irq);

  assert_no_enable_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (en == '0) |-> !irq);
endmodule

bind gpio_apb gpio_apb_chk #(.W(W), .AW(AW)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .oe_a(pins_oe[W-1:0]), .irq(irq),
  .en(en_q), .msk(msk_q), .latch(latch_q), .hit(hit)
);

// File: tb/gpio_apb_test.sv
module gpio_apb_test;
  localparam int NP = 4, W = 32, AW = 7;
  logic clk = 0, rstn = 0;
  logic psel = 0, penable = 0, pwrite = 0, deb_tick = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [NP*W-1:0] pins_in = '0, pins_out, pins_oe;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_apb #(.NPORTS(NP), .W(W), .DB_TICKS(4), .AW(AW)) uut (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .deb_tick(deb_tick),
    .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq));

  initial forever begin
    repeat (3) @(negedge clk);
    deb_tick = 1;
    @(negedge clk);
    deb_tick = 0;
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = AW'(a); pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = AW'(a); penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R11 out reg", d, 0);
    rd(8'h30, d); check("R11 enable reg", d, 0);
    check("R11 pins_oe", pins_oe, 0);
    check("R11 irq", irq, 0);
  endtask

  task automatic t_ports;
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      wr(8'(12*p), 32'hA5000000 | p);
      wr(8'(12*p + 4), 32'h00FF00F0 ^ p);
    end
    for (int p = 0; p < NP; p++) begin
      rd(8'(12*p + 4), d); check("R1 dir readback", d, 32'h00FF00F0 ^ p);
      check("R1 pins_out", pins_out[p*W +: W], 32'hA5000000 | p);
      check("R1 pins_oe", pins_oe[p*W +: W], 32'h00FF00F0 ^ p);
    end
  endtask

  task automatic t_ext;
    logic [31:0] d;
    @(negedge clk);
    pins_in[2*W +: W] = 32'h1234_8765;
    wait_clk(3);
    rd(8'h58, d); check("R2 ext port C", d, 32'h1234_8765);
    pins_in[2*W +: W] = 0;
    pins_in[W +: W] = 32'hFFFF_0000;
    wait_clk(3);
    check("R8 port B no irq", irq, 0);
    rd(8'h54, d); check("R2 ext port B", d, 32'hFFFF_0000);
    pins_in[W +: W] = 0;
    wait_clk(3);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(8'h38, 32'h0000_0003);
    wr(8'h3c, 32'h0000_0001);
    wr(8'h30, 32'h0000_0003);
    pins_in[0] = 1; pins_in[1] = 1;
    wait_clk(4);
    rd(8'h40, d); check("R3 rising latched only bit0", d, 32'h1);
    pins_in[0] = 0; pins_in[1] = 0;
    wait_clk(4);
    rd(8'h40, d); check("R3 falling latched bit1 rise sticky", d, 32'h3);
    check("R10 irq high", irq, 1);
    wr(8'h4c, 32'h1);
    rd(8'h40, d); check("R4 per-bit clear", d, 32'h2);
    wr(8'h4c, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R4 clear all", d, 32'h0);
    check("R10 irq low", irq, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(8'h38, 32'h0);
    wr(8'h3c, 32'h4);
    wr(8'h30, 32'h0000_000C);
    wait_clk(4);
    rd(8'h40, d); check("R5 low-active bit3 set", d, 32'h8);
    pins_in[2] = 1; pins_in[3] = 1;
    wait_clk(4);
    rd(8'h40, d); check("R5 high-active bit2", d, 32'h4);
    wr(8'h4c, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R5 clear no effect", d, 32'h4);
    wr(8'h34, 32'h4);
    rd(8'h40, d); check("R6 masked status", d, 0);
    check("R6 masked irq", irq, 0);
    wr(8'h34, 32'h0);
    check("R6 unmask reveals", irq, 1);
    wr(8'h30, 32'h0);
    rd(8'h40, d); check("R7 disabled status", d, 0);
    check("R7 disabled irq", irq, 0);
    wr(8'h30, 32'h4);
    pins_in[2] = 0;
    wait_clk(4);
    check("R5 level drops", irq, 0);
    pins_in[3] = 0;
    wr(8'h30, 32'h0);
  endtask

  task automatic t_debounce;
    logic [31:0] d;
    wr(8'h38, 32'h20);
    wr(8'h3c, 32'h20);
    wr(8'h48, 32'h20);
    wr(8'h30, 32'h20);
    pins_in[5] = 1;
    wait_clk(3);
    pins_in[5] = 0;
    wait_clk(30);
    rd(8'h40, d); check("R9 glitch rejected", d, 0);
    pins_in[5] = 1;
    wait_clk(40);
    rd(8'h40, d); check("R9 stable accepted", d, 32'h20);
    check("R9 irq", irq, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rstn = 1;
    wait_clk(2);
    t_reset();
    t_ports();
    t_ext();
    t_edges();
    t_level();
    t_debounce();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule